// File: doc/BRIEF.md
# CR predicate-result element sequencer

This block walks the elements of a vectorised operation whose only result is a condition-register value, one element per clock, and decides for each element whether that value reaches the condition register. A start pulse captures the vector length, the predicate mask and the control bits. The block then presents the element index on `wr_idx` and takes the operation's result for that element on `op_res` in the same cycle. It answers with a write strobe and the data to store.

Two result shapes are supported. In field mode the result is a 4-bit condition field, and a 2-bit selector picks which of its bits is tested. In bit mode the result is a single condition bit, and that bit itself is tested. An element whose predicate bit is clear is either dropped (zeroing off) or given a substitute result made of the "set-non-zero" bit. That substitute is one copy in bit mode and four copies in field mode. The element then goes through the same test as any other. A write happens only when the tested bit equals the invert control. The destination is addressed as base plus `wr_idx`.

Top module: `crpr_elem_seq`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are all 0.
- R2: A `start` pulse while idle captures the inputs. From the next cycle, `busy` is high for exactly N cycles, where N is `vl_in` clamped to MAXVL. A `start` raised while busy has no effect on the running vector.
- R3: `done` is a one-cycle pulse in the cycle after the last element. With a vector length of 0, it comes in the cycle after `start`, and no element cycle occurs.
- R4: Element i uses predicate bit `mask_in[i]`. With `sz_in`=0, an element whose predicate bit is 0 never asserts `wr_en`.
- R5: With `sz_in`=1, a masked-out element takes the substitute result. In field mode (`field_mode_in`=1) this is `{4{snz_in}}`. In bit mode it is `{3'b000, snz_in}`.
- R6: An active element takes `op_res` unchanged in field mode. In bit mode it takes `{3'b000, op_res[0]}`.
- R7: In field mode the tested bit is `result[bit_sel_in]`, with selector value k naming bit k of `wr_data`. In bit mode the tested bit is `result[0]`.
- R8: `wr_en` is 1 exactly when the element is active or substituted and the tested bit equals `inv_in`. Otherwise the store is cancelled.
- R9: A substituted result is subject to the same test as an operation result. It is not written unconditionally.
- R10: During each element cycle, `wr_idx` equals the element index. Indices run 0, 1, ... N-1 in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a vector; honoured only while idle |
| vl_in | input | VLW | Vector length, clamped to MAXVL |
| mask_in | input | MAXVL | Predicate mask, bit i for element i |
| sz_in | input | 1 | 1: masked-out elements get a substitute result |
| snz_in | input | 1 | Bit value used for substitute results |
| inv_in | input | 1 | Value the tested bit must equal for a write |
| bit_sel_in | input | 2 | Bit of a 4-bit field result that is tested |
| field_mode_in | input | 1 | 1: 4-bit field results, 0: single-bit results |
| op_res | input | 4 | Operation result for the element on `wr_idx` |
| wr_en | output | 1 | Condition-register write strobe |
| wr_data | output | 4 | Data to write; bit mode uses bit 0 only |
| wr_idx | output | IDXW | Element index, destination offset |
| busy | output | 1 | An element is presented this cycle |
| done | output | 1 | One-cycle pulse after the final element |

## Verification
A wrong element counter shows at once at the ports: `wr_idx` skips or repeats, the busy window has the wrong length, or `done` arrives a cycle early or late. A wrong predicate bit selection, substitute value or test-bit selection appears as a wrong `wr_en` or `wr_data` in that same element cycle. The stimulus therefore mixes sparse, full and empty masks with every selector value in both result shapes. Every element is compared cycle by cycle, so a fault becomes visible within one clock of the element it affects.

// File: rtl/crpr_pkg.sv
package crpr_pkg;

   localparam int CRF_W = 4;

   typedef enum logic {
      MODE_BIT   = 1'b0,
      MODE_FIELD = 1'b1
   } crpr_mode_e;

   typedef struct packed {
      logic       sz;
      logic       snz;
      logic       inv;
      logic [1:0] bit_sel;
      crpr_mode_e mode;
   } crpr_ctl_t;

endpackage

// File: rtl/crpr_cfg_latch.sv
module crpr_cfg_latch
   import crpr_pkg::*;
#(
   parameter int MAXVL = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [MAXVL-1:0] mask_in,
   input  crpr_ctl_t        ctl_in,
   output logic [MAXVL-1:0] mask_q,
   output crpr_ctl_t        ctl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         ctl_q  <= '0;
      end else if (load) begin
         mask_q <= mask_in;
         ctl_q  <= ctl_in;
      end
   end

endmodule

// File: rtl/crpr_step_ctrl.sv
module crpr_step_ctrl #(
   parameter int MAXVL = 64,
   parameter int VLW   = $clog2(MAXVL + 1),
   parameter int IDXW  = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [VLW-1:0]  vl_in,
   output logic            load,
   output logic            busy,
   output logic [IDXW-1:0] idx,
   output logic            last,
   output logic            done
);

   localparam logic [VLW-1:0] VL_CAP = VLW'(MAXVL);

   logic [VLW-1:0] vl_eff;
   logic [VLW-1:0] vl_lim;
   logic [VLW-1:0] idx_next_ext;

   always_comb begin
      vl_eff       = (vl_in > VL_CAP) ? VL_CAP : vl_in;
      load         = start && !busy;
      idx_next_ext = VLW'(idx) + VLW'(1);
      last         = busy && (idx_next_ext == vl_lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         idx    <= '0;
         done   <= 1'b0;
         vl_lim <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               idx    <= '0;
               vl_lim <= vl_eff;
               if (vl_eff == '0) begin
                  done <= 1'b1;
               end else begin
                  busy <= 1'b1;
               end
            end
         end else if (last) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            idx <= idx + IDXW'(1);
         end
      end
   end

   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(last)) |-> (idx == $past(idx) + IDXW'(1))); // R10

   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (VLW'(idx) < vl_lim)); // R2

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R3

   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (!busy && done)); // R3

endmodule

// File: rtl/crpr_elem_eval.sv
module crpr_elem_eval
   import crpr_pkg::*;
#(
   parameter int MAXVL = 64,
   parameter int IDXW  = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  logic [IDXW-1:0]  idx,
   input  logic [MAXVL-1:0] mask,
   input  crpr_ctl_t        ctl,
   input  logic [CRF_W-1:0] op_res,
   output logic             wr_en,
   output logic [CRF_W-1:0] wr_data
);

   logic             pred_bit;
   logic             active;
   logic             subst;
   logic [CRF_W-1:0] result;
   logic             test_bit;

   always_comb begin
      pred_bit = mask[idx];
      active   = valid && pred_bit;
      subst    = valid && !pred_bit && ctl.sz;
   end

   always_comb begin
      result = '0;
      if (active) begin
         if (ctl.mode == MODE_FIELD) result = op_res;
         else                        result = {{(CRF_W-1){1'b0}}, op_res[0]};
      end else if (subst) begin
         if (ctl.mode == MODE_FIELD) result = {CRF_W{ctl.snz}};
         else                        result = {{(CRF_W-1){1'b0}}, ctl.snz};
      end
   end

   always_comb begin
      test_bit = (ctl.mode == MODE_FIELD) ? result[ctl.bit_sel] : result[0];
      wr_en    = (active || subst) && (test_bit == ctl.inv);
      wr_data  = result;
   end

   AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> !wr_en); // R8

   AST_MASKED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !mask[idx] && !ctl.sz) |-> !wr_en); // R4

   AST_BIT_MODE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ctl.mode == MODE_BIT) |-> (wr_data[CRF_W-1:1] == '0)); // R6

   AST_WRITE_MATCHES_INV: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ctl.mode == MODE_FIELD) |-> (wr_data[ctl.bit_sel] == ctl.inv)); // R7

endmodule

// File: rtl/crpr_elem_seq.sv
module crpr_elem_seq
   import crpr_pkg::*;
#(
   parameter int MAXVL   = 64,
   parameter int OUT_REG = 0,
   parameter int VLW     = $clog2(MAXVL + 1),
   parameter int IDXW    = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [VLW-1:0]   vl_in,
   input  logic [MAXVL-1:0] mask_in,
   input  logic             sz_in,
   input  logic             snz_in,
   input  logic             inv_in,
   input  logic [1:0]       bit_sel_in,
   input  logic             field_mode_in,
   input  logic [3:0]       op_res,
   output logic             wr_en,
   output logic [3:0]       wr_data,
   output logic [IDXW-1:0]  wr_idx,
   output logic             busy,
   output logic             done
);

   if (MAXVL < 1) begin : g_bad_maxvl
      $error("crpr_elem_seq: MAXVL must be at least 1");
   end
   if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_outreg
      $error("crpr_elem_seq: OUT_REG must be 0 or 1");
   end
   if (CRF_W != 4) begin : g_bad_crfw
      $error("crpr_elem_seq: condition field width must be 4");
   end

   crpr_ctl_t        ctl_in;
   crpr_ctl_t        ctl_q;
   logic [MAXVL-1:0] mask_q;
   logic             load;
   logic             run;
   logic [IDXW-1:0]  idx;
   logic             last;
   logic             done_c;
   logic             en_c;
   logic [3:0]       data_c;

   always_comb begin
      ctl_in.sz      = sz_in;
      ctl_in.snz     = snz_in;
      ctl_in.inv     = inv_in;
      ctl_in.bit_sel = bit_sel_in;
      ctl_in.mode    = field_mode_in ? MODE_FIELD : MODE_BIT;
   end

   crpr_step_ctrl #(.MAXVL(MAXVL), .VLW(VLW), .IDXW(IDXW)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .vl_in (vl_in),
      .load  (load),
      .busy  (run),
      .idx   (idx),
      .last  (last),
      .done  (done_c)
   );

   crpr_cfg_latch #(.MAXVL(MAXVL)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .mask_in (mask_in),
      .ctl_in  (ctl_in),
      .mask_q  (mask_q),
      .ctl_q   (ctl_q)
   );

   crpr_elem_eval #(.MAXVL(MAXVL), .IDXW(IDXW)) u_eval (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (run),
      .idx     (idx),
      .mask    (mask_q),
      .ctl     (ctl_q),
      .op_res  (op_res),
      .wr_en   (en_c),
      .wr_data (data_c)
   );

   if (OUT_REG == 1) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_data <= '0;
            wr_idx  <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
         end else begin
            wr_en   <= en_c;
            wr_data <= data_c;
            wr_idx  <= idx;
            busy    <= run;
            done    <= done_c;
         end
      end
   end else begin : g_out_comb
      always_comb begin
         wr_en   = en_c;
         wr_data = data_c;
         wr_idx  = idx;
         busy    = run;
         done    = done_c;
      end
   end

   AST_NO_WRITE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !wr_en); // R2

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done); // R3

   AST_LAST_UNUSED_OK: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> run); // R10

endmodule

// File: tb/crpr_elem_seq_tb.sv
`timescale 1ns/1ps
module crpr_elem_seq_tb;

   localparam int MAXVL = 16;
   localparam int VLW   = 5;
   localparam int IDXW  = 4;

   typedef struct packed {
      logic [4:0]  vl;
      logic [15:0] mask;
      logic        sz;
      logic        snz;
      logic        inv;
      logic [1:0]  bsel;
      logic        fmode;
      logic [3:0]  seed;
   } vec_t;

   localparam int NVEC = 9;
   localparam vec_t TBL [NVEC] = '{
      '{5'd8,  16'h00A5, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 4'd3},
      '{5'd8,  16'h005A, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 4'd9},
      '{5'd8,  16'h000F, 1'b1, 1'b0, 1'b0, 2'd3, 1'b1, 4'd5},
      '{5'd6,  16'h0033, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 4'd2},
      '{5'd7,  16'h006C, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 4'd7},
      '{5'd20, 16'hFFFF, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 4'd0},
      '{5'd16, 16'h0000, 1'b1, 1'b1, 1'b1, 2'd3, 1'b1, 4'd1},
      '{5'd1,  16'h0001, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 4'd15},
      '{5'd9,  16'h0100, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 4'd6}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [VLW-1:0]   vl_in = '0;
   logic [MAXVL-1:0] mask_in = '0;
   logic             sz_in = 1'b0;
   logic             snz_in = 1'b0;
   logic             inv_in = 1'b0;
   logic [1:0]       bit_sel_in = '0;
   logic             field_mode_in = 1'b0;
   logic [3:0]       op_res = '0;
   logic             wr_en;
   logic [3:0]       wr_data;
   logic [IDXW-1:0]  wr_idx;
   logic             busy;
   logic             done;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   crpr_elem_seq #(.MAXVL(MAXVL)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
      .mask_in(mask_in), .sz_in(sz_in), .snz_in(snz_in), .inv_in(inv_in),
      .bit_sel_in(bit_sel_in), .field_mode_in(field_mode_in), .op_res(op_res),
      .wr_en(wr_en), .wr_data(wr_data), .wr_idx(wr_idx), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] opfn(input logic [3:0] seed, input int e);
      int t;
      t = int'(seed) + e * 3 + (e >> 2);
      return t[3:0];
   endfunction

   task automatic run_vec(input vec_t v, input bit poke_start);
      int n;
      logic [3:0] res;
      logic tb;
      logic act, sub, exp_en;
      n = (v.vl > 5'd16) ? 16 : int'(v.vl);
      @(negedge clk);
      vl_in = v.vl; mask_in = v.mask; sz_in = v.sz; snz_in = v.snz;
      inv_in = v.inv; bit_sel_in = v.bsel; field_mode_in = v.fmode;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (n == 0) begin
         #1;
         chk(done == 1'b1, "R3 empty-done", int'(done), 1);
         chk(busy == 1'b0, "R3 empty-busy", int'(busy), 0);
         @(negedge clk);
         chk(done == 1'b0, "R3 empty-pulse", int'(done), 0);
         return;
      end
      for (int e = 0; e < n; e++) begin
         op_res = opfn(v.seed, e);
         if (poke_start && e == 1) begin
            start = 1'b1; vl_in = 5'd1; mask_in = 16'h0000; inv_in = ~v.inv;
         end
         if (poke_start && e == 2) start = 1'b0;
         #1;
         act = v.mask[e];
         sub = !v.mask[e] && v.sz;
         res = 4'b0000;
         if (act) res = v.fmode ? op_res : {3'b000, op_res[0]};
         else if (sub) res = v.fmode ? {4{v.snz}} : {3'b000, v.snz};
         tb = v.fmode ? res[v.bsel] : res[0];
         exp_en = (act || sub) && (tb == v.inv);
         chk(busy == 1'b1, "R2 busy", int'(busy), 1);
         chk(int'(wr_idx) == e, "R10 index", int'(wr_idx), e);
         chk(done == 1'b0, "R3 no early done", int'(done), 0);
         if (!act && !v.sz)
            chk(wr_en == 1'b0, "R4 masked skip", int'(wr_en), 0);
         else if (sub)
            chk(wr_en == exp_en, "R9 substitute test", int'(wr_en), int'(exp_en));
         else
            chk(wr_en == exp_en, "R8 write decision", int'(wr_en), int'(exp_en));
         if (exp_en) begin
            if (sub) chk(wr_data == res, "R5 substitute data", int'(wr_data), int'(res));
            else if (v.fmode) chk(wr_data == res, "R7 field data", int'(wr_data), int'(res));
            else chk(wr_data == res, "R6 bit data", int'(wr_data), int'(res));
         end
         if (e < n - 1) @(negedge clk);
      end
      @(negedge clk);
      #1;
      chk(busy == 1'b0, "R2 busy length", int'(busy), 0);
      chk(done == 1'b1, "R3 done", int'(done), 1);
      chk(wr_en == 1'b0, "R2 idle no write", int'(wr_en), 0);
      @(negedge clk);
      chk(done == 1'b0, "R3 done pulse", int'(done), 0);
   endtask

   initial begin
      #4_000_000;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      vec_t d;
      repeat (3) @(negedge clk);
      #1;
      chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
      chk(done == 1'b0, "R1 reset done", int'(done), 0);
      chk(wr_en == 1'b0, "R1 reset wr_en", int'(wr_en), 0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) run_vec(TBL[i], 1'b0);

      // R3: empty vector
      d = '{5'd0, 16'hFFFF, 1'b1, 1'b1, 1'b1, 2'd0, 1'b1, 4'd0};
      run_vec(d, 1'b0);

      // R2: start while busy is ignored
      d = '{5'd5, 16'h0015, 1'b1, 1'b0, 1'b1, 2'd3, 1'b1, 4'd11};
      run_vec(d, 1'b1);

      // R7: every selector value in field mode
      for (int s = 0; s < 4; s++) begin
         d = '{5'd6, 16'h002D, 1'b1, 1'b1, 1'b0, s[1:0], 1'b1, 4'(s * 5)};
         run_vec(d, 1'b0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule